// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block provides the two source operand values for the decode stage of an in-order pipeline. Every cycle it takes the two source register indices and the raw values read from the register file. It compares those indices against the destinations of the three older instructions still in flight: the one in execute, the one in memory access and the one in writeback. Where an older instruction is about to write a register that decode reads, the block returns that instruction's result in place of the stale register-file value. The operand handed to decode is therefore the value the register would hold once all older instructions had retired in program order.

Instructions that do not write a register carry register 0 as their destination. Bubbles, stores, jumps and branches are marked this way, so the block needs no separate write-enable. Each stage still has a valid flag. An instruction in execute that is a load has no data yet, so it cannot supply a usable operand. When such a load is the selected producer, the block raises a not-ready flag, and the stall controller uses that flag to hold the consumer.

The outputs are registered. Each operand and the flag appear one clock after the inputs that produce them. Both operands are resolved by identical, independent logic.

Top module: `fwd_decode_unit`

## Requirements
- R1: While `rst` is high at a rising edge, both operand outputs become 0 and `opnd_notready` becomes 0 after that edge.
- R2: The outputs change only at rising edges. Each one reflects the inputs sampled at the most recent edge, with a latency of one cycle.
- R3: A source index of 0 yields an operand of 0, whatever the register-file data and stage contents are, and it never raises `opnd_notready`.
- R4: A nonzero source index that matches no valid in-flight destination yields the register-file data for that operand.
- R5: A nonzero source index that matches the valid execute-stage destination yields the execute-stage result, ahead of any other match.
- R6: When the execute stage does not match, a match on the valid memory-stage destination yields the memory-stage result, ahead of the writeback stage.
- R7: When neither younger stage matches, a match on the valid writeback-stage destination yields the writeback result and not the register-file data. This covers a write and a read of the same register in one cycle.
- R8: A stage whose valid flag is 0 never supplies an operand, even when its destination equals the source index. A destination of 0 never matches a read.
- R9: `opnd_notready` is 1 exactly when, for at least one operand with a nonzero index, the matching producer is the valid execute-stage entry and `ex_is_load` is 1. Operand selection itself follows R5 in that case.
- R10: Operand B is resolved from `rs_b_idx` and `rf_b_data` by the same rules, independently of operand A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rs_a_idx | input | IDX_W | Source index of operand A |
| rs_b_idx | input | IDX_W | Source index of operand B |
| rf_a_data | input | DATA_W | Register-file read data for operand A |
| rf_b_data | input | DATA_W | Register-file read data for operand B |
| ex_vld | input | 1 | Execute-stage entry is valid |
| ex_dst | input | IDX_W | Execute-stage destination index (0 means no write) |
| ex_res | input | DATA_W | Execute-stage result |
| ex_is_load | input | 1 | Execute-stage entry is a load whose data is not yet available |
| mem_vld | input | 1 | Memory-stage entry is valid |
| mem_dst | input | IDX_W | Memory-stage destination index |
| mem_res | input | DATA_W | Memory-stage result |
| wb_vld | input | 1 | Writeback-stage entry is valid |
| wb_dst | input | IDX_W | Writeback-stage destination index |
| wb_res | input | DATA_W | Writeback-stage result |
| opnd_a | output | DATA_W | Registered operand A |
| opnd_b | output | DATA_W | Registered operand B |
| opnd_notready | output | 1 | Registered flag: a selected producer is a pending load |

## Verification
The bench builds the block with IDX_W=3 and DATA_W=8, which gives eight registers. With that size, one 16-bit counter can sweep every combination of operand A's source index, all three destinations, all three valid flags and the load flag. That covers each priority ordering, each coincidence of equal destinations and each masked stage, all in about 65k cycles. Operand B is driven with the complementary index, so it takes the same cases in a different arrangement. Short directed sequences before and after the sweep cover reset and one-cycle latency.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // Number of in-flight producer stages visible to decode.
  localparam int unsigned FWD_STAGES = 3;
  // Stage slot order: lower slot = younger producer = higher priority.
  localparam int unsigned STG_EX  = 0;
  localparam int unsigned STG_MEM = 1;
  localparam int unsigned STG_WB  = 2;
  // Number of operands the decode stage reads.
  localparam int unsigned FWD_PORTS = 2;
endpackage

// File: rtl/fwd_hit_detect.sv
module fwd_hit_detect
  import fwd_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0]                  src_idx,
  input  logic [FWD_STAGES-1:0]             stg_vld,
  input  logic [FWD_STAGES-1:0][IDX_W-1:0]  stg_dst,
  output logic [FWD_STAGES-1:0]             hit,
  output logic                              src_is_zero
);
  assign src_is_zero = (src_idx == '0);

  for (genvar g = 0; g < FWD_STAGES; g++) begin : g_cmp
    // Destination 0 marks a non-writing instruction; index 0 is never bypassed.
    assign hit[g] = stg_vld[g] && !src_is_zero && (stg_dst[g] == src_idx);
  end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [FWD_STAGES-1:0]              hit,
  input  logic                               src_is_zero,
  input  logic [FWD_STAGES-1:0][DATA_W-1:0]  stg_res,
  input  logic [DATA_W-1:0]                  rf_data,
  output logic [DATA_W-1:0]                  value
);
  always_comb begin
    value = rf_data;
    // Walk from the oldest slot to the youngest so the youngest hit overrides.
    for (int i = FWD_STAGES - 1; i >= 0; i--) begin
      if (hit[i]) value = stg_res[i];
    end
    if (src_is_zero) value = '0;
  end
endmodule

// File: rtl/fwd_decode_unit.sv
module fwd_decode_unit
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rs_a_idx,
  input  logic [IDX_W-1:0]  rs_b_idx,
  input  logic [DATA_W-1:0] rf_a_data,
  input  logic [DATA_W-1:0] rf_b_data,
  input  logic              ex_vld,
  input  logic [IDX_W-1:0]  ex_dst,
  input  logic [DATA_W-1:0] ex_res,
  input  logic              ex_is_load,
  input  logic              mem_vld,
  input  logic [IDX_W-1:0]  mem_dst,
  input  logic [DATA_W-1:0] mem_res,
  input  logic              wb_vld,
  input  logic [IDX_W-1:0]  wb_dst,
  input  logic [DATA_W-1:0] wb_res,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic              opnd_notready
);
  // Stage bundles, slot order taken from the package.
  logic [FWD_STAGES-1:0]             stg_vld;
  logic [FWD_STAGES-1:0][IDX_W-1:0]  stg_dst;
  logic [FWD_STAGES-1:0][DATA_W-1:0] stg_res;

  always_comb begin
    stg_vld[STG_EX]  = ex_vld;
    stg_vld[STG_MEM] = mem_vld;
    stg_vld[STG_WB]  = wb_vld;
    stg_dst[STG_EX]  = ex_dst;
    stg_dst[STG_MEM] = mem_dst;
    stg_dst[STG_WB]  = wb_dst;
    stg_res[STG_EX]  = ex_res;
    stg_res[STG_MEM] = mem_res;
    stg_res[STG_WB]  = wb_res;
  end

  // Per-operand request bundles.
  logic [FWD_PORTS-1:0][IDX_W-1:0]  port_idx;
  logic [FWD_PORTS-1:0][DATA_W-1:0] port_rf;
  logic [FWD_PORTS-1:0][DATA_W-1:0] port_val;
  logic [FWD_PORTS-1:0]             port_wait;

  assign port_idx[0] = rs_a_idx;
  assign port_idx[1] = rs_b_idx;
  assign port_rf[0]  = rf_a_data;
  assign port_rf[1]  = rf_b_data;

  for (genvar p = 0; p < FWD_PORTS; p++) begin : g_port
    logic [FWD_STAGES-1:0] hit;
    logic                  is_zero;

    fwd_hit_detect #(.IDX_W(IDX_W)) u_hit (
      .src_idx     (port_idx[p]),
      .stg_vld     (stg_vld),
      .stg_dst     (stg_dst),
      .hit         (hit),
      .src_is_zero (is_zero)
    );

    fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
      .hit         (hit),
      .src_is_zero (is_zero),
      .stg_res     (stg_res),
      .rf_data     (port_rf[p]),
      .value       (port_val[p])
    );

    // Execute-stage hit has top priority, so it alone decides staleness.
    assign port_wait[p] = hit[STG_EX] && ex_is_load;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_a        <= '0;
      opnd_b        <= '0;
      opnd_notready <= 1'b0;
    end else begin
      opnd_a        <= port_val[0];
      opnd_b        <= port_val[1];
      opnd_notready <= |port_wait;
    end
  end
endmodule

// File: rtl/fwd_decode_unit_chk.sv
module fwd_decode_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  rs_a_idx,
  input logic              ex_vld,
  input logic [IDX_W-1:0]  ex_dst,
  input logic [DATA_W-1:0] ex_res,
  input logic              ex_is_load,
  input logic              mem_vld,
  input logic [IDX_W-1:0]  mem_dst,
  input logic              wb_vld,
  input logic [IDX_W-1:0]  wb_dst,
  input logic [DATA_W-1:0] wb_res,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              opnd_notready
);
  logic rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    // R1
    if (rst_q && !rst) begin
      reset_clear_chk: assert (opnd_a == '0 && opnd_b == '0 && !opnd_notready);
    end
  end

  // R3
  zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rs_a_idx) == '0) |-> (opnd_a == '0));

  // R5
  ex_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rs_a_idx) != '0 && $past(ex_vld) &&
     $past(ex_dst) == $past(rs_a_idx)) |-> (opnd_a == $past(ex_res)));

  // R7
  wb_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rs_a_idx) != '0 &&
     $past(wb_vld) && $past(wb_dst) == $past(rs_a_idx) &&
     !($past(mem_vld) && $past(mem_dst) == $past(rs_a_idx)) &&
     !($past(ex_vld) && $past(ex_dst) == $past(rs_a_idx)))
    |-> (opnd_a == $past(wb_res)));

  // R9
  notready_cause_chk: assert property (@(posedge clk) disable iff (rst)
    opnd_notready |-> ($past(ex_vld) && $past(ex_is_load) && $past(ex_dst) != '0));
endmodule

bind fwd_decode_unit fwd_decode_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .rs_a_idx      (rs_a_idx),
  .ex_vld        (ex_vld),
  .ex_dst        (ex_dst),
  .ex_res        (ex_res),
  .ex_is_load    (ex_is_load),
  .mem_vld       (mem_vld),
  .mem_dst       (mem_dst),
  .wb_vld        (wb_vld),
  .wb_dst        (wb_dst),
  .wb_res        (wb_res),
  .opnd_a        (opnd_a),
  .opnd_b        (opnd_b),
  .opnd_notready (opnd_notready)
);

// File: tb/fwd_decode_unit_test.sv
`timescale 1ns/1ps
module fwd_decode_unit_test;
  localparam int unsigned DW = 8;
  localparam int unsigned IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [IW-1:0] rs_a_idx = '0, rs_b_idx = '0;
  logic [DW-1:0] rf_a_data = '0, rf_b_data = '0;
  logic          ex_vld = 1'b0, ex_is_load = 1'b0, mem_vld = 1'b0, wb_vld = 1'b0;
  logic [IW-1:0] ex_dst = '0, mem_dst = '0, wb_dst = '0;
  logic [DW-1:0] ex_res = '0, mem_res = '0, wb_res = '0;
  logic [DW-1:0] opnd_a, opnd_b;
  logic          opnd_notready;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  fwd_decode_unit #(.DATA_W(DW), .IDX_W(IW)) uut (
    .clk(clk), .rst(rst),
    .rs_a_idx(rs_a_idx), .rs_b_idx(rs_b_idx),
    .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
    .ex_vld(ex_vld), .ex_dst(ex_dst), .ex_res(ex_res), .ex_is_load(ex_is_load),
    .mem_vld(mem_vld), .mem_dst(mem_dst), .mem_res(mem_res),
    .wb_vld(wb_vld), .wb_dst(wb_dst), .wb_res(wb_res),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_notready(opnd_notready)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_val(input logic [IW-1:0] idx, input logic [DW-1:0] rf);
    if (idx == 0) return '0;
    if (ex_vld && ex_dst == idx) return ex_res;
    if (mem_vld && mem_dst == idx) return mem_res;
    if (wb_vld && wb_dst == idx) return wb_res;
    return rf;
  endfunction

  function automatic string model_tag(input logic [IW-1:0] idx);
    if (idx == 0) return "R3";
    if (ex_vld && ex_dst == idx) return "R5";
    if (mem_vld && mem_dst == idx) return "R6";
    if (wb_vld && wb_dst == idx) return "R7";
    if (ex_dst == idx || mem_dst == idx || wb_dst == idx) return "R8";
    return "R4";
  endfunction

  function automatic logic model_wait(input logic [IW-1:0] idx);
    return (idx != 0) && ex_vld && ex_dst == idx && ex_is_load;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog all R actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [DW-1:0] ea, eb;
    logic          en;
    string         ta, tb;
    // Reset with busy inputs: R1
    rf_a_data = 8'h5A; rf_b_data = 8'hA5; rs_a_idx = 3'd2; rs_b_idx = 3'd3;
    ex_vld = 1'b1; ex_dst = 3'd2; ex_is_load = 1'b1; ex_res = 8'h77;
    repeat (3) @(posedge clk);
    #1;
    check("R1 opnd_a", opnd_a, '0);
    check("R1 opnd_b", opnd_b, '0);
    check("R1 notready", {7'd0, opnd_notready}, 8'd0);

    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R5 first", opnd_a, 8'h77);
    check("R9 first", {7'd0, opnd_notready}, 8'd1);

    // R2: new inputs do not reach outputs before the edge
    @(negedge clk);
    ex_vld = 1'b0; ex_is_load = 1'b0;
    #1;
    check("R2 hold a", opnd_a, 8'h77);
    check("R2 hold nr", {7'd0, opnd_notready}, 8'd1);
    @(posedge clk); #1;
    check("R2 update a", opnd_a, 8'h5A);
    check("R2 update nr", {7'd0, opnd_notready}, 8'd0);

    // Exhaustive sweep
    for (int c = 0; c < 65536; c++) begin
      @(negedge clk);
      rs_a_idx   = c[2:0];
      rs_b_idx   = ~c[2:0];
      ex_dst     = c[5:3];
      mem_dst    = c[8:6];
      wb_dst     = c[11:9];
      ex_vld     = c[12];
      mem_vld    = c[13];
      wb_vld     = c[14];
      ex_is_load = c[15];
      ex_res     = c[7:0] ^ 8'hE1;
      mem_res    = c[15:8] ^ 8'h3C;
      wb_res     = c[7:0] + 8'h55;
      rf_a_data  = {1'b1, c[13:7]} ^ 8'h12;
      rf_b_data  = {c[6:0], 1'b1} ^ 8'h48;
      ea = model_val(rs_a_idx, rf_a_data);
      eb = model_val(rs_b_idx, rf_b_data);
      en = model_wait(rs_a_idx) || model_wait(rs_b_idx);
      ta = model_tag(rs_a_idx);
      tb = model_tag(rs_b_idx);
      @(posedge clk); #1;
      check({ta, " opnd_a"}, opnd_a, ea);
      check({"R10 ", tb, " opnd_b"}, opnd_b, eb);
      check("R9 notready", {7'd0, opnd_notready}, {7'd0, en});
    end

    // Reset mid-run clears outputs: R1
    @(negedge clk);
    rst = 1'b1; rs_a_idx = 3'd5; rf_a_data = 8'hFF; ex_vld = 1'b1; ex_dst = 3'd5; ex_is_load = 1'b1;
    @(posedge clk); #1;
    check("R1 mid opnd_a", opnd_a, '0);
    check("R1 mid notready", {7'd0, opnd_notready}, 8'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule